// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes stack-organised instructions that name no operand registers. A small operand stack is held in internal registers. Data moves between that stack and a local data memory only through two memory-addressed instructions. One copies a memory word onto the top of the stack. The other stores the top of the stack to memory and removes it. The arithmetic instructions carry no address: each one takes the two topmost entries, removes both, and leaves one result in their place.

Instructions arrive one at a time over a valid/ready handshake. Each accepted instruction finishes in a single clock edge and signals completion with a one-cycle pulse. The local memory has a write port for preloading and a combinational read port for inspection. Stack misuse raises two sticky fault flags, one for overflow and one for underflow, and a faulting instruction leaves the stack and memory untouched. Expression evaluation works in the usual stack-machine order. For example, push A, push B, add, push C, push D, add, multiply, store X puts (A+B)*(C+D) in X and leaves the stack empty.

Top module: `stack_exec_unit`

## Requirements
- R1: While reset is asserted and after it is released, the stack depth is 0, the visible top value is 0, both fault flags are 0, the done pulse is 0, and ready is 1 when no preload write is pending.
- R2: An instruction is accepted on a rising clock edge when valid and ready are both high. Ready is low in any cycle where the preload write enable is high, and an instruction offered then has no effect. After every accepted instruction, the done output is high for exactly the one cycle that follows the accepting edge.
- R3: PUSH (opcode 1) reads the data-memory word at its address field, places it on top of the stack, and increases the depth by one.
- R4: POP (opcode 2) writes the top stack entry into the data memory at its address field and decreases the depth by one.
- R5: ADD (opcode 3) removes the two top entries and pushes their sum modulo 2^16, so the depth falls by one.
- R6: SUB (opcode 4) pushes the second-from-top entry minus the top entry, modulo 2^16, and the depth falls by one.
- R7: MUL (opcode 5) pushes the low 16 bits of the product of the two top entries, and the depth falls by one.
- R8: A PUSH at depth 8 sets the overflow flag and leaves the stack contents and depth unchanged. The flag stays set until reset.
- R9: A POP at depth 0, or an ADD, SUB or MUL at depth below 2, sets the underflow flag and leaves the stack, depth and memory unchanged. The flag stays set until reset.
- R10: The eight-instruction program that pushes A, pushes B, adds, pushes C, pushes D, adds, multiplies and pops to X leaves (A+B)*(C+D) in memory word X and an empty stack.
- R11: Opcode 0 (no-op) and the reserved opcodes 6 and 7 are accepted and produce a done pulse, but change neither the stack nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | Instruction offered |
| instReady | output | 1 | Unit can accept an instruction this cycle |
| instOp | input | 3 | Opcode: 0 no-op, 1 PUSH, 2 POP, 3 ADD, 4 SUB, 5 MUL |
| instAddr | input | ADDR_W (6) | Memory address for PUSH and POP |
| memLoadEn | input | 1 | Preload write enable for the data memory |
| memLoadAddr | input | ADDR_W (6) | Preload write address |
| memLoadData | input | DATA_W (16) | Preload write data |
| memRdAddr | input | ADDR_W (6) | Inspection read address |
| memRdData | output | DATA_W (16) | Memory word at memRdAddr, combinational |
| doneOut | output | 1 | One-cycle completion pulse |
| depthOut | output | 4 | Current number of stack entries, 0 to 8 |
| topOut | output | DATA_W (16) | Top stack entry, 0 when empty |
| overflowFlag | output | 1 | Sticky overflow indication |
| underflowFlag | output | 1 | Sticky underflow indication |

## Verification
The bench targets operand order in subtraction. A design that swaps the operands returns 2 instead of 0xFFFE for 5 minus 7. It also targets wrap-around in addition and multiplication, where a design that saturates or keeps the high product bits shows the wrong top value. The full-stack and short-stack cases check that a faulting instruction leaves the entries intact: a design that still writes on overflow corrupts the eighth entry, and one that still stores on an empty-stack POP overwrites the target memory word. A PUSH offered while a preload is being written must be dropped, and the no-op and reserved opcodes must pulse done without touching the depth.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_MUL  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } stkOp_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_MUL = 2'd2
  } aluSel_e;

  // Strobes from control to datapath, valid in the accepting cycle.
  typedef struct packed {
    logic    pushMem;
    logic    popMem;
    logic    arith;
    aluSel_e aluSel;
  } stkStrobe_t;

endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  aluSel_e             aluSel,
  input  logic [DATA_W-1:0]   opSecond,
  input  logic [DATA_W-1:0]   opTop,
  output logic [DATA_W-1:0]   aluRes
);

  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] fullProduct;

  always_comb begin
    fullProduct = PROD_W'(opSecond) * PROD_W'(opTop);
    unique case (aluSel)
      ALU_ADD: aluRes = opSecond + opTop;
      ALU_SUB: aluRes = opSecond - opTop;
      ALU_MUL: aluRes = fullProduct[DATA_W-1:0];
      default: aluRes = '0;
    endcase
  end

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int STACK_DEPTH = 8,
  parameter int DEPTH_W     = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  logic [2:0]         instOp,
  input  logic               memLoadEn,
  output logic               instReady,
  output stkStrobe_t         strobe,
  output logic [DEPTH_W-1:0] depth,
  output logic               overflowFlag,
  output logic               underflowFlag,
  output logic               doneOut
);

  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(STACK_DEPTH);
  localparam logic [DEPTH_W-1:0] ONE  = DEPTH_W'(1);
  localparam logic [DEPTH_W-1:0] TWO  = DEPTH_W'(2);

  stkOp_e             opDec;
  logic               accept;
  logic               ovfHit;
  logic               udfHit;
  logic               isArith;
  logic [DEPTH_W-1:0] depthNext;

  assign instReady = ~memLoadEn;
  assign accept    = instValid & instReady;
  assign opDec     = stkOp_e'(instOp);
  assign isArith   = (opDec == OP_ADD) || (opDec == OP_SUB) || (opDec == OP_MUL);

  // Decode into strobes and fault hits.
  always_comb begin
    strobe = '{pushMem: 1'b0, popMem: 1'b0, arith: 1'b0, aluSel: ALU_ADD};
    ovfHit = 1'b0;
    udfHit = 1'b0;
    if (accept) begin
      unique case (opDec)
        OP_PUSH: begin
          if (depth == FULL) ovfHit = 1'b1;
          else               strobe.pushMem = 1'b1;
        end
        OP_POP: begin
          if (depth == '0) udfHit = 1'b1;
          else             strobe.popMem = 1'b1;
        end
        OP_ADD, OP_SUB, OP_MUL: begin
          if (depth < TWO) udfHit = 1'b1;
          else             strobe.arith = 1'b1;
          if (opDec == OP_SUB)      strobe.aluSel = ALU_SUB;
          else if (opDec == OP_MUL) strobe.aluSel = ALU_MUL;
          else                      strobe.aluSel = ALU_ADD;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    depthNext = depth;
    if (strobe.pushMem)                     depthNext = depth + ONE;
    else if (strobe.popMem || strobe.arith) depthNext = depth - ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth         <= '0;
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
      doneOut       <= 1'b0;
    end else begin
      depth         <= depthNext;
      overflowFlag  <= overflowFlag | ovfHit;
      underflowFlag <= underflowFlag | udfHit;
      doneOut       <= accept;
    end
  end

  // Depth never exceeds the stack size.
  a_r1_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    depth <= FULL);

  a_r2_done_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> doneOut);

  a_r2_no_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !doneOut);

  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opDec == OP_PUSH && depth != FULL) |=> depth == $past(depth) + ONE);

  a_r5_arith_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isArith && depth >= TWO) |=> depth == $past(depth) - ONE);

  a_r8_full_push_hold: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opDec == OP_PUSH && depth == FULL) |=> (depth == FULL && overflowFlag));

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  a_r9_empty_pop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opDec == OP_POP && depth == '0) |=> (depth == '0 && underflowFlag));

  a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    underflowFlag |=> underflowFlag);

  a_r11_nop_keeps_depth: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (opDec == OP_NOP || opDec == OP_RSV6 || opDec == OP_RSV7)) |=> $stable(depth));

endmodule

// File: rtl/stk_datapath.sv
module stk_datapath
  import stk_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int STACK_DEPTH = 8,
  parameter int ADDR_W      = 6,
  parameter int DEPTH_W     = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  stkStrobe_t         strobe,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [ADDR_W-1:0]  instAddr,
  input  logic               memLoadEn,
  input  logic [ADDR_W-1:0]  memLoadAddr,
  input  logic [DATA_W-1:0]  memLoadData,
  input  logic [ADDR_W-1:0]  memRdAddr,
  output logic [DATA_W-1:0]  memRdData,
  output logic [DATA_W-1:0]  topData
);

  localparam int MEM_WORDS = 1 << ADDR_W;
  localparam int IDX_W     = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam logic [DEPTH_W-1:0] ONE = DEPTH_W'(1);
  localparam logic [DEPTH_W-1:0] TWO = DEPTH_W'(2);

  logic [DATA_W-1:0]  stackReg [STACK_DEPTH];
  logic [DATA_W-1:0]  dataMem  [MEM_WORDS];

  logic [DEPTH_W-1:0] topIdxW;
  logic [DEPTH_W-1:0] secIdxW;
  logic [IDX_W-1:0]   topIdx;
  logic [IDX_W-1:0]   secIdx;
  logic [IDX_W-1:0]   pushIdx;
  logic [DATA_W-1:0]  topVal;
  logic [DATA_W-1:0]  secVal;
  logic [DATA_W-1:0]  aluRes;
  logic [DATA_W-1:0]  fetchVal;

  assign topIdxW  = depth - ONE;
  assign secIdxW  = depth - TWO;
  assign topIdx   = topIdxW[IDX_W-1:0];
  assign secIdx   = secIdxW[IDX_W-1:0];
  assign pushIdx  = depth[IDX_W-1:0];
  assign topVal   = stackReg[topIdx];
  assign secVal   = stackReg[secIdx];
  assign fetchVal = dataMem[instAddr];

  assign topData   = (depth == '0) ? '0 : topVal;
  assign memRdData = dataMem[memRdAddr];

  stk_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .aluSel   (strobe.aluSel),
    .opSecond (secVal),
    .opTop    (topVal),
    .aluRes   (aluRes)
  );

  // Stack entries: index 0 is the bottom, depth-1 the top.
  always_ff @(posedge clk) begin
    if (strobe.pushMem)    stackReg[pushIdx] <= fetchVal;
    else if (strobe.arith) stackReg[secIdx]  <= aluRes;
  end

  // Data memory: preload write has the port when enabled.
  always_ff @(posedge clk) begin
    if (memLoadEn)          dataMem[memLoadAddr] <= memLoadData;
    else if (strobe.popMem) dataMem[instAddr]    <= topVal;
  end

  a_r4_pop_stores_top: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popMem |=> dataMem[$past(instAddr)] == $past(topVal));

  a_r3_push_shows_word: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushMem |=> topData == $past(fetchVal));

  a_r2_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.pushMem, strobe.popMem, strobe.arith}) <= 1);

endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit
  import stk_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int STACK_DEPTH = 8,
  parameter int ADDR_W      = 6,
  parameter int DEPTH_W     = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  output logic               instReady,
  input  logic [2:0]         instOp,
  input  logic [ADDR_W-1:0]  instAddr,
  input  logic               memLoadEn,
  input  logic [ADDR_W-1:0]  memLoadAddr,
  input  logic [DATA_W-1:0]  memLoadData,
  input  logic [ADDR_W-1:0]  memRdAddr,
  output logic [DATA_W-1:0]  memRdData,
  output logic               doneOut,
  output logic [DEPTH_W-1:0] depthOut,
  output logic [DATA_W-1:0]  topOut,
  output logic               overflowFlag,
  output logic               underflowFlag
);

  stkStrobe_t         strobe;
  logic [DEPTH_W-1:0] depth;

  stk_ctrl #(
    .STACK_DEPTH (STACK_DEPTH),
    .DEPTH_W     (DEPTH_W)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .instValid     (instValid),
    .instOp        (instOp),
    .memLoadEn     (memLoadEn),
    .instReady     (instReady),
    .strobe        (strobe),
    .depth         (depth),
    .overflowFlag  (overflowFlag),
    .underflowFlag (underflowFlag),
    .doneOut       (doneOut)
  );

  stk_datapath #(
    .DATA_W      (DATA_W),
    .STACK_DEPTH (STACK_DEPTH),
    .ADDR_W      (ADDR_W),
    .DEPTH_W     (DEPTH_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .depth       (depth),
    .instAddr    (instAddr),
    .memLoadEn   (memLoadEn),
    .memLoadAddr (memLoadAddr),
    .memLoadData (memLoadData),
    .memRdAddr   (memRdAddr),
    .memRdData   (memRdData),
    .topData     (topOut)
  );

  assign depthOut = depth;

endmodule

// File: tb/stack_exec_unit_bench.sv
module stack_exec_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic        instReady;
  logic [2:0]  instOp = 3'd0;
  logic [5:0]  instAddr = '0;
  logic        memLoadEn = 1'b0;
  logic [5:0]  memLoadAddr = '0;
  logic [15:0] memLoadData = '0;
  logic [5:0]  memRdAddr = '0;
  logic [15:0] memRdData;
  logic        doneOut;
  logic [3:0]  depthOut;
  logic [15:0] topOut;
  logic        overflowFlag;
  logic        underflowFlag;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stack_exec_unit u_stack_exec_unit (
    .clk (clk), .rstN (rstN),
    .instValid (instValid), .instReady (instReady),
    .instOp (instOp), .instAddr (instAddr),
    .memLoadEn (memLoadEn), .memLoadAddr (memLoadAddr), .memLoadData (memLoadData),
    .memRdAddr (memRdAddr), .memRdData (memRdData),
    .doneOut (doneOut), .depthOut (depthOut), .topOut (topOut),
    .overflowFlag (overflowFlag), .underflowFlag (underflowFlag)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [5:0]  addr;
    logic [3:0]  expDepth;
    logic [15:0] expTop;
    logic [3:0]  req;
  } vec_t;

  // Memory before the table: M[1]=5 M[2]=7 M[3]=3 M[4]=100 M[5]=FFFF
  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{3'd1, 6'd1,  4'd1, 16'h0005, 4'd3},  // R3 push 5
    '{3'd1, 6'd2,  4'd2, 16'h0007, 4'd3},  // R3 push 7
    '{3'd4, 6'd0,  4'd1, 16'hFFFE, 4'd6},  // R6 5-7 wraps
    '{3'd1, 6'd3,  4'd2, 16'h0003, 4'd3},
    '{3'd5, 6'd0,  4'd1, 16'hFFFA, 4'd7},  // R7 low product bits
    '{3'd1, 6'd4,  4'd2, 16'h0064, 4'd3},
    '{3'd3, 6'd0,  4'd1, 16'h005E, 4'd5},  // R5 sum wraps
    '{3'd1, 6'd5,  4'd2, 16'hFFFF, 4'd3},
    '{3'd3, 6'd0,  4'd1, 16'h005D, 4'd5},
    '{3'd2, 6'd10, 4'd0, 16'h0000, 4'd4},  // R4 store to M[10]
    '{3'd0, 6'd0,  4'd0, 16'h0000, 4'd11}  // R11 no-op
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic preload(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    memLoadEn = 1'b1; memLoadAddr = a; memLoadData = d;
    @(negedge clk);
    memLoadEn = 1'b0;
  endtask

  // Drive at a falling edge, accept at the rising edge, sample at the next falling edge.
  task automatic exec(input logic [2:0] op, input logic [5:0] a);
    @(negedge clk);
    instValid = 1'b1; instOp = op; instAddr = a;
    @(negedge clk);
    instValid = 1'b0;
  endtask

  function automatic logic [15:0] peek(input logic [5:0] a);
    memRdAddr = a;
    return memRdData;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rd;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", depthOut, 0, "depth in reset");
    chk("R1", doneOut, 0, "done in reset");
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", {overflowFlag, underflowFlag}, 0, "flags after reset");
    chk("R1", topOut, 0, "top after reset");
    chk("R1", instReady, 1, "ready after reset");

    preload(6'd1, 16'h0005);
    preload(6'd2, 16'h0007);
    preload(6'd3, 16'h0003);
    preload(6'd4, 16'h0064);
    preload(6'd5, 16'hFFFF);
    preload(6'd20, 16'h1234);

    for (int i = 0; i < NVEC; i++) begin
      exec(VECS[i].op, VECS[i].addr);
      checks++;
      if (depthOut !== VECS[i].expDepth || topOut !== VECS[i].expTop || doneOut !== 1'b1) begin
        fails++;
        $display("FAIL R%0d row %0d: actual depth %0d top %0h done %0b expected depth %0d top %0h done 1",
                 VECS[i].req, i, depthOut, topOut, doneOut, VECS[i].expDepth, VECS[i].expTop);
      end
    end
    rd = peek(6'd10);
    #1;
    chk("R4", memRdData, 16'h005D, "M[10] after POP");
    chk("R2", {overflowFlag, underflowFlag}, 0, "no flags on legal table");
    @(negedge clk);
    chk("R2", doneOut, 0, "done lasts one cycle");

    // R2 instruction offered during preload is dropped
    @(negedge clk);
    memLoadEn = 1'b1; memLoadAddr = 6'd21; memLoadData = 16'h0BAD;
    instValid = 1'b1; instOp = 3'd1; instAddr = 6'd1;
    #1;
    chk("R2", instReady, 0, "ready low during preload");
    @(negedge clk);
    memLoadEn = 1'b0; instValid = 1'b0;
    chk("R2", depthOut, 0, "push during preload ignored");
    chk("R2", doneOut, 0, "no done for refused push");

    // R9 underflow: empty POP must not write memory
    exec(3'd2, 6'd20);
    chk("R9", underflowFlag, 1, "underflow on empty POP");
    chk("R9", depthOut, 0, "depth after empty POP");
    chk("R9", doneOut, 1, "done on faulting POP");
    rd = peek(6'd20);
    #1;
    chk("R9", memRdData, 16'h1234, "memory untouched by empty POP");
    exec(3'd1, 6'd3);
    exec(3'd4, 6'd0);
    chk("R9", depthOut, 1, "SUB with one entry keeps depth");
    chk("R9", topOut, 16'h0003, "SUB with one entry keeps top");
    chk("R9", underflowFlag, 1, "underflow sticky");
    chk("R8", overflowFlag, 0, "overflow clear on underflow");

    // R11 reserved opcodes
    exec(3'd7, 6'd1);
    chk("R11", {depthOut, topOut}, {4'd1, 16'h0003}, "opcode 7 no effect");
    chk("R11", doneOut, 1, "opcode 7 done pulse");
    exec(3'd6, 6'd2);
    chk("R11", {depthOut, topOut}, {4'd1, 16'h0003}, "opcode 6 no effect");

    // R8 overflow
    doReset();
    chk("R1", {depthOut, overflowFlag, underflowFlag}, 0, "state cleared by reset");
    for (int k = 0; k < 8; k++) exec(3'd1, 6'd1);
    chk("R8", depthOut, 8, "depth at full");
    exec(3'd1, 6'd2);
    chk("R8", overflowFlag, 1, "overflow on full push");
    chk("R8", {depthOut, topOut}, {4'd8, 16'h0005}, "full push keeps stack");
    exec(3'd2, 6'd11);
    rd = peek(6'd11);
    #1;
    chk("R8", memRdData, 16'h0005, "eighth entry intact");
    chk("R8", {depthOut, overflowFlag}, {4'd7, 1'b1}, "overflow sticky after pop");

    // R10 expression program
    doReset();
    preload(6'd30, 16'd2);
    preload(6'd31, 16'd3);
    preload(6'd32, 16'd4);
    preload(6'd33, 16'd5);
    exec(3'd1, 6'd30);
    exec(3'd1, 6'd31);
    exec(3'd3, 6'd0);
    exec(3'd1, 6'd32);
    exec(3'd1, 6'd33);
    exec(3'd3, 6'd0);
    exec(3'd5, 6'd0);
    chk("R10", topOut, 16'd45, "product on top");
    exec(3'd2, 6'd40);
    rd = peek(6'd40);
    #1;
    chk("R10", memRdData, 16'd45, "M[X] result");
    chk("R10", {depthOut, overflowFlag, underflowFlag}, 0, "empty stack no faults");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule